// File: doc/BRIEF.md
# Dual Phase-Frequency Detector with Shared Monitor Output

This block holds two phase-frequency detectors, one for an intermediate-frequency loop (IF) and one for a radio-frequency loop (RF). Each detector compares the rising edges of a divided reference against those of a divided oscillator feedback. From that comparison it drives pump-up, pump-down and float (high impedance) controls for its charge pump. A per-loop slope bit sets the polarity. A float request or a powerdown silences the pump. Each loop also has a current-level request, which the block applies only when a new comparison cycle begins. The analog pump current is outside this block.

Each loop has a lock monitor. It declares lock once the comparison pulses have stayed narrow for a run of consecutive cycles. A single monitor pin is steered by a 4-bit select word. The pin can show either loop's lock indication or both combined, any one of the four divider signals, a fastlock resistor switch control, or a constant low. One select code also requests a reset of all the loop counters. A flag output marks the fastlock high-current condition.

Divider inputs are level signals synchronous to `clk`. Rising edges are found inside the block.

Top module: `dual_pfd_monitor`

## Requirements
- R1: After reset, all pump-up and pump-down outputs are low, both current-level outputs are low, and with select 0000 the monitor pin, `fast_flag` and `cnt_clr` are low.
- R2: With slope bit high, a reference rising edge that arrives while no feedback edge is pending raises pump-up from the next cycle. Pump-up stays high until the clock edge that sees the feedback rising edge, so its width in cycles equals the edge separation. A feedback edge that arrives first gives pump-down in the same way. Edges that arrive on the same cycle produce no pulse. Pump-up and pump-down are never high together.
- R3: With slope bit low, the pump-up and pump-down roles of R2 are swapped.
- R4: While a loop's float or powerdown input is high, its pump-up and pump-down are low and its float output is high. Float alone keeps the pending phase state, so the pulse resumes when float is released. Powerdown clears that state and the loop's lock.
- R5: The phase state spans one cycle of lead or lag (±2π). Further edges on the leading input add nothing. A single edge on the other input ends the pulse, and the next edge of that input starts the opposite pulse.
- R6: A comparison pulse is good if it ends narrower than LOCK_TOL cycles (default 4). A zero-width comparison also counts as good. A loop becomes locked after LOCK_CNT consecutive good comparisons (default 4). Any pulse that reaches LOCK_TOL cycles clears the count at once.
- R7: The select word is osel = {osel[3], osel[2], osel[1], osel[0]}. Codes 0100, 1000 and 1100 put IF lock, RF lock, or IF-and-RF lock on `mon_out`. A loop's lock indication is high while the loop is locked, except during the cycles its pump pulse is active.
- R8: Codes ?001, ?010, ?101 and ?110 (? = either value) put `if_ref`, `rf_ref`, `if_fb` and `rf_fb` respectively on `mon_out`.
- R9: Codes 0000, 0111 and 1011 drive `mon_out` low.
- R10: Code 0011 is fastlock. `mon_out` is the inverse of `rf_cur_hi`, so it is pulled low in high-current mode, and `fast_flag` equals `rf_cur_hi`. Under any other code `fast_flag` is low.
- R11: A loop's current-level output takes the value of its request only on a cycle whose clock edge sees a reference rising edge of that loop. Otherwise it holds.
- R12: Code 1111 raises `cnt_clr` and holds `mon_out` low. It also clears the phase state and lock count of both loops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_ref | input | 1 | IF divided reference level |
| if_fb | input | 1 | IF divided feedback level |
| rf_ref | input | 1 | RF divided reference level |
| rf_fb | input | 1 | RF divided feedback level |
| if_pol | input | 1 | IF slope bit (1 = positive slope) |
| rf_pol | input | 1 | RF slope bit |
| if_hiz | input | 1 | IF pump float request |
| rf_hiz | input | 1 | RF pump float request |
| if_pwdn | input | 1 | IF powerdown |
| rf_pwdn | input | 1 | RF powerdown |
| if_cur_req | input | 1 | IF high-current request |
| rf_cur_req | input | 1 | RF high-current request |
| osel | input | 4 | Monitor select code |
| if_up | output | 1 | IF pump-up control |
| if_dn | output | 1 | IF pump-down control |
| if_tri | output | 1 | IF pump float control |
| rf_up | output | 1 | RF pump-up control |
| rf_dn | output | 1 | RF pump-down control |
| rf_tri | output | 1 | RF pump float control |
| if_cur_hi | output | 1 | IF applied current level |
| rf_cur_hi | output | 1 | RF applied current level |
| mon_out | output | 1 | Shared monitor pin |
| fast_flag | output | 1 | Fastlock high-current flag |
| cnt_clr | output | 1 | Counter reset request |

## Verification
The assertions assume that the divider, control and select inputs change only between active clock edges and are held low while reset is applied. The stimulus therefore drives every input on the falling clock edge and starts all dividers low. The current-hold property reads a reference rising edge as the level moving from low to high between two sampled edges. The stimulus holds each divider level for at least one full cycle, so every transition is visible to both the design and the properties.

// File: rtl/pfd_mon_pkg.sv
package pfd_mon_pkg;

  localparam int unsigned CH_IF  = 0;
  localparam int unsigned CH_RF  = 1;
  localparam int unsigned NUM_CH = 2;

  localparam logic [3:0] SEL_OFF    = 4'b0000;
  localparam logic [3:0] SEL_LK_IF  = 4'b0100;
  localparam logic [3:0] SEL_LK_RF  = 4'b1000;
  localparam logic [3:0] SEL_LK_ALL = 4'b1100;
  localparam logic [3:0] SEL_FAST   = 4'b0011;
  localparam logic [3:0] SEL_CLEAR  = 4'b1111;

  typedef struct packed {
    logic up;
    logic dn;
    logic hiz;
  } pump_ctl_t;

  typedef struct packed {
    logic active;
    logic cmp_end;
    logic cmp_zero;
  } pfd_evt_t;

endpackage

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_mon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_lvl,
  input  logic      fb_lvl,
  input  logic      pos_slope,
  input  logic      float_req,
  input  logic      kill,
  input  logic      cur_req,
  output pump_ctl_t pump,
  output pfd_evt_t  evt,
  output logic      cur_hi
);

  logic ref_q, fb_q, up_q, dn_q, cur_q;
  logic ref_edge, fb_edge, arm_up, arm_dn, meet;
  logic up_d, dn_d, cur_en, active;

  // next state: edge capture, meet-and-clear, kill
  always_comb begin
    ref_edge = ref_lvl & ~ref_q;
    fb_edge  = fb_lvl & ~fb_q;
    arm_up   = up_q | ref_edge;
    arm_dn   = dn_q | fb_edge;
    meet     = arm_up & arm_dn;
    up_d     = arm_up & ~meet & ~kill;
    dn_d     = arm_dn & ~meet & ~kill;
    cur_en   = ref_edge;
    active   = up_q | dn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cur_q <= 1'b0;
    end else begin
      ref_q <= ref_lvl;
      fb_q  <= fb_lvl;
      up_q  <= up_d;
      dn_q  <= dn_d;
      if (cur_en) begin
        cur_q <= cur_req;
      end
    end
  end

  always_comb begin
    pump.hiz     = float_req;
    pump.up      = ~float_req & (pos_slope ? up_q : dn_q);
    pump.dn      = ~float_req & (pos_slope ? dn_q : up_q);
    evt.active   = active;
    evt.cmp_end  = active & meet & ~kill;
    evt.cmp_zero = ~active & ref_edge & fb_edge & ~kill;
    cur_hi       = cur_q;
  end

endmodule

// File: rtl/lock_mon.sv
module lock_mon
  import pfd_mon_pkg::*;
#(
  parameter int unsigned LOCK_TOL = 4,
  parameter int unsigned LOCK_CNT = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  pfd_evt_t evt,
  input  logic     kill,
  output logic     lock_pin
);

  localparam int unsigned RUN_W  = $clog2(LOCK_TOL + 1);
  localparam int unsigned GOOD_W = $clog2(LOCK_CNT + 1);
  localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(LOCK_TOL);
  localparam logic [RUN_W-1:0]  RUN_LIM  = RUN_W'(LOCK_TOL - 1);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_CNT);

  logic [RUN_W-1:0]  run_q, run_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic too_wide, good_evt, locked;

  always_comb begin
    too_wide = evt.active & (run_q >= RUN_LIM);
    good_evt = (evt.cmp_end & ~too_wide) | evt.cmp_zero;

    if (kill) begin
      run_d = '0;
    end else if (evt.active & ~evt.cmp_end) begin
      run_d = (run_q == RUN_MAX) ? run_q : run_q + RUN_W'(1);
    end else begin
      run_d = '0;
    end

    if (kill | too_wide) begin
      good_d = '0;
    end else if (good_evt && (good_q != GOOD_MAX)) begin
      good_d = good_q + GOOD_W'(1);
    end else begin
      good_d = good_q;
    end

    locked   = (good_q == GOOD_MAX);
    lock_pin = locked & ~evt.active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      good_q <= '0;
    end else begin
      run_q  <= run_d;
      good_q <= good_d;
    end
  end

endmodule

// File: rtl/mon_mux.sv
module mon_mux
  import pfd_mon_pkg::*;
(
  input  logic [3:0]        osel,
  input  logic [NUM_CH-1:0] lock_pin,
  input  logic [NUM_CH-1:0] ref_lvl,
  input  logic [NUM_CH-1:0] fb_lvl,
  input  logic              rf_cur,
  output logic              mon_out,
  output logic              fast_flag,
  output logic              cnt_clr
);

  always_comb begin
    mon_out   = 1'b0;
    fast_flag = 1'b0;
    cnt_clr   = 1'b0;
    casez (osel)
      SEL_LK_IF:  mon_out = lock_pin[CH_IF];
      SEL_LK_RF:  mon_out = lock_pin[CH_RF];
      SEL_LK_ALL: mon_out = &lock_pin;
      4'b?001:    mon_out = ref_lvl[CH_IF];
      4'b?010:    mon_out = ref_lvl[CH_RF];
      4'b?101:    mon_out = fb_lvl[CH_IF];
      4'b?110:    mon_out = fb_lvl[CH_RF];
      SEL_FAST: begin
        mon_out   = ~rf_cur;
        fast_flag = rf_cur;
      end
      SEL_CLEAR:  cnt_clr = 1'b1;
      default:    mon_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/dual_pfd_monitor.sv
module dual_pfd_monitor
  import pfd_mon_pkg::*;
#(
  parameter int unsigned LOCK_TOL = 4,
  parameter int unsigned LOCK_CNT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_ref,
  input  logic       if_fb,
  input  logic       rf_ref,
  input  logic       rf_fb,
  input  logic       if_pol,
  input  logic       rf_pol,
  input  logic       if_hiz,
  input  logic       rf_hiz,
  input  logic       if_pwdn,
  input  logic       rf_pwdn,
  input  logic       if_cur_req,
  input  logic       rf_cur_req,
  input  logic [3:0] osel,
  output logic       if_up,
  output logic       if_dn,
  output logic       if_tri,
  output logic       rf_up,
  output logic       rf_dn,
  output logic       rf_tri,
  output logic       if_cur_hi,
  output logic       rf_cur_hi,
  output logic       mon_out,
  output logic       fast_flag,
  output logic       cnt_clr
);

  logic [NUM_CH-1:0] ref_v, fb_v, pol_v, hiz_v, pwdn_v, creq_v;
  logic [NUM_CH-1:0] float_v, kill_v, cur_v, lock_v;
  pump_ctl_t         pump_v [NUM_CH];
  pfd_evt_t          evt_v  [NUM_CH];

  assign ref_v  = {rf_ref, if_ref};
  assign fb_v   = {rf_fb, if_fb};
  assign pol_v  = {rf_pol, if_pol};
  assign hiz_v  = {rf_hiz, if_hiz};
  assign pwdn_v = {rf_pwdn, if_pwdn};
  assign creq_v = {rf_cur_req, if_cur_req};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign float_v[c] = hiz_v[c] | pwdn_v[c];
    assign kill_v[c]  = pwdn_v[c] | cnt_clr;

    pfd_core u_pfd (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_lvl   (ref_v[c]),
      .fb_lvl    (fb_v[c]),
      .pos_slope (pol_v[c]),
      .float_req (float_v[c]),
      .kill      (kill_v[c]),
      .cur_req   (creq_v[c]),
      .pump      (pump_v[c]),
      .evt       (evt_v[c]),
      .cur_hi    (cur_v[c])
    );

    lock_mon #(
      .LOCK_TOL (LOCK_TOL),
      .LOCK_CNT (LOCK_CNT)
    ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_v[c]),
      .kill     (kill_v[c]),
      .lock_pin (lock_v[c])
    );
  end

  mon_mux u_mux (
    .osel      (osel),
    .lock_pin  (lock_v),
    .ref_lvl   (ref_v),
    .fb_lvl    (fb_v),
    .rf_cur    (cur_v[CH_RF]),
    .mon_out   (mon_out),
    .fast_flag (fast_flag),
    .cnt_clr   (cnt_clr)
  );

  assign if_up     = pump_v[CH_IF].up;
  assign if_dn     = pump_v[CH_IF].dn;
  assign if_tri    = pump_v[CH_IF].hiz;
  assign rf_up     = pump_v[CH_RF].up;
  assign rf_dn     = pump_v[CH_RF].dn;
  assign rf_tri    = pump_v[CH_RF].hiz;
  assign if_cur_hi = cur_v[CH_IF];
  assign rf_cur_hi = cur_v[CH_RF];

endmodule

// File: rtl/pfd_mon_chk.sv
module pfd_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       if_ref,
  input logic       rf_ref,
  input logic       if_hiz,
  input logic       rf_hiz,
  input logic       if_pwdn,
  input logic       rf_pwdn,
  input logic [3:0] osel,
  input logic       if_up,
  input logic       if_dn,
  input logic       if_tri,
  input logic       rf_up,
  input logic       rf_dn,
  input logic       rf_tri,
  input logic       if_cur_hi,
  input logic       rf_cur_hi,
  input logic       mon_out,
  input logic       fast_flag,
  input logic       cnt_clr
);

  AST_IF_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (if_hiz || if_pwdn) |-> (!if_up && !if_dn && if_tri)); // R4
  AST_RF_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_hiz || rf_pwdn) |-> (!rf_up && !rf_dn && rf_tri)); // R4
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_up && if_dn) && !(rf_up && rf_dn)); // R2
  AST_IF_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(if_ref) |=> $stable(if_cur_hi)); // R11
  AST_RF_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rf_ref) |=> $stable(rf_cur_hi)); // R11
  AST_CLEAR_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (osel == 4'hF) |-> (cnt_clr && !mon_out)); // R12
  AST_CLEAR_PUMPS: assert property (@(posedge clk) disable iff (!rst_n)
    (osel == 4'hF) |=> (!if_up && !if_dn && !rf_up && !rf_dn)); // R12
  AST_FAST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fast_flag |-> (osel == 4'h3 && rf_cur_hi && !mon_out)); // R10
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (osel == 4'h0 || osel == 4'h7 || osel == 4'hB) |-> !mon_out); // R9

endmodule

bind dual_pfd_monitor pfd_mon_chk u_chk (.*);

// File: tb/tb_dual_pfd_monitor.sv
module tb_dual_pfd_monitor;

  localparam int TOL = 4;
  localparam int CNT = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_d [2];
  logic fb_d  [2];
  logic pol   [2];
  logic hiz   [2];
  logic pwdn  [2];
  logic creq  [2];
  logic [3:0] osel;
  logic if_up, if_dn, if_tri, rf_up, rf_dn, rf_tri;
  logic if_cur_hi, rf_cur_hi, mon_out, fast_flag, cnt_clr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";
  int cnt_up [2];
  int cnt_dn [2];

  // behavioural model state
  int m_pend [2];
  int m_w    [2];
  int m_good [2];
  bit m_pr   [2];
  bit m_pf   [2];
  bit m_cur  [2];

  always #2 clk = ~clk;

  dual_pfd_monitor dut (
    .clk(clk), .rst_n(rst_n),
    .if_ref(ref_d[0]), .if_fb(fb_d[0]), .rf_ref(ref_d[1]), .rf_fb(fb_d[1]),
    .if_pol(pol[0]), .rf_pol(pol[1]), .if_hiz(hiz[0]), .rf_hiz(hiz[1]),
    .if_pwdn(pwdn[0]), .rf_pwdn(pwdn[1]),
    .if_cur_req(creq[0]), .rf_cur_req(creq[1]), .osel(osel),
    .if_up(if_up), .if_dn(if_dn), .if_tri(if_tri),
    .rf_up(rf_up), .rf_dn(rf_dn), .rf_tri(rf_tri),
    .if_cur_hi(if_cur_hi), .rf_cur_hi(rf_cur_hi),
    .mon_out(mon_out), .fast_flag(fast_flag), .cnt_clr(cnt_clr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_pend[c] = 0; m_w[c] = 0; m_good[c] = 0;
        m_pr[c] = 0; m_pf[c] = 0; m_cur[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit r, f, act, kl;
        int np;
        r   = ref_d[c] && !m_pr[c];
        f   = fb_d[c] && !m_pf[c];
        act = (m_pend[c] != 0);
        kl  = pwdn[c] || (osel == 4'hF);
        if (r && f)      np = 0;
        else if (r)      np = (m_pend[c] == -1) ? 0 : 1;
        else if (f)      np = (m_pend[c] == 1) ? 0 : -1;
        else             np = m_pend[c];
        if (kl) begin
          m_pend[c] = 0; m_w[c] = 0; m_good[c] = 0;
        end else begin
          if (act && (m_w[c] + 1 >= TOL)) m_good[c] = 0;
          else if ((act && np == 0) || (!act && r && f))
            m_good[c] = (m_good[c] < CNT) ? m_good[c] + 1 : CNT;
          m_w[c]    = (act && np != 0) ? m_w[c] + 1 : 0;
          m_pend[c] = np;
        end
        if (r) m_cur[c] = creq[c];
        m_pr[c] = ref_d[c];
        m_pf[c] = fb_d[c];
      end
    end
  end

  function automatic bit lk(input int c);
    return (m_good[c] == CNT) && (m_pend[c] == 0);
  endfunction

  function automatic bit exp_mon();
    if (osel == 4'h0 || osel == 4'h7 || osel == 4'hB || osel == 4'hF) return 1'b0;
    if (osel == 4'h3) return !m_cur[1];
    if (osel[1:0] == 2'b00) begin
      if (osel[3:2] == 2'b01) return lk(0);
      if (osel[3:2] == 2'b10) return lk(1);
      return lk(0) && lk(1);
    end
    case (osel[2:0])
      3'd1:    return ref_d[0];
      3'd2:    return ref_d[1];
      3'd5:    return fb_d[0];
      default: return fb_d[1];
    endcase
  endfunction

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit tr [2];
    @(negedge clk);
    for (int c = 0; c < 2; c++) tr[c] = hiz[c] || pwdn[c];
    chk(tag, "if_up",  if_up,  !tr[0] && (pol[0] ? m_pend[0] == 1 : m_pend[0] == -1));
    chk(tag, "if_dn",  if_dn,  !tr[0] && (pol[0] ? m_pend[0] == -1 : m_pend[0] == 1));
    chk(tag, "if_tri", if_tri, tr[0]);
    chk(tag, "rf_up",  rf_up,  !tr[1] && (pol[1] ? m_pend[1] == 1 : m_pend[1] == -1));
    chk(tag, "rf_dn",  rf_dn,  !tr[1] && (pol[1] ? m_pend[1] == -1 : m_pend[1] == 1));
    chk(tag, "rf_tri", rf_tri, tr[1]);
    chk(tag, "if_cur_hi", if_cur_hi, m_cur[0]);
    chk(tag, "rf_cur_hi", rf_cur_hi, m_cur[1]);
    chk(tag, "mon_out", mon_out, exp_mon());
    chk(tag, "fast_flag", fast_flag, (osel == 4'h3) && m_cur[1]);
    chk(tag, "cnt_clr", cnt_clr, osel == 4'hF);
    cnt_up[0] += int'(if_up); cnt_dn[0] += int'(if_dn);
    cnt_up[1] += int'(rf_up); cnt_dn[1] += int'(rf_dn);
  endtask

  task automatic clr_counts();
    for (int c = 0; c < 2; c++) begin cnt_up[c] = 0; cnt_dn[c] = 0; end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < 2; c++) begin ref_d[c] = 0; fb_d[c] = 0; end
    for (int k = 0; k < n; k++) tick();
  endtask

  // one comparison cycle on channel c, feedback lagging by lag cycles
  task automatic cmp(input int c, input int lag);
    int a, b;
    a = (lag < 0) ? -lag : 0;
    b = (lag > 0) ? lag : 0;
    for (int k = 0; k < 20; k++) begin
      ref_d[c] = (k >= a && k < a + 6);
      fb_d[c]  = (k >= b && k < b + 6);
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; osel = 4'h0;
    for (int c = 0; c < 2; c++) begin
      ref_d[c] = 0; fb_d[c] = 0; pol[c] = 1; hiz[c] = 0; pwdn[c] = 0; creq[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    tick();
    chk("R1", "reset pumps", {if_up, if_dn, rf_up, rf_dn}, 0);
    chk("R1", "reset cur", {if_cur_hi, rf_cur_hi}, 0);
    chk("R1", "reset pin", {mon_out, fast_flag, cnt_clr}, 0);
    idle(2);

    tag = "R2";
    clr_counts(); cmp(0, 3);
    chk("R2", "up width lag3", cnt_up[0], 3);
    clr_counts(); cmp(0, -2);
    chk("R2", "dn width lead2", cnt_dn[0], 2);
    clr_counts(); cmp(0, 0);
    chk("R2", "zero lag pulses", cnt_up[0] + cnt_dn[0], 0);
    clr_counts(); cmp(1, 5);
    chk("R2", "rf up width lag5", cnt_up[1], 5);

    tag = "R3";
    pol[0] = 0;
    clr_counts(); cmp(0, 3);
    chk("R3", "swapped dn width", cnt_dn[0], 3);
    chk("R3", "swapped up width", cnt_up[0], 0);
    pol[0] = 1;
    idle(2);

    tag = "R5";
    clr_counts();
    for (int k = 0; k < 24; k++) begin
      ref_d[0] = (k < 2) || (k >= 4 && k < 6) || (k >= 16 && k < 18);
      fb_d[0]  = (k >= 8 && k < 10) || (k >= 12 && k < 14);
      tick();
    end
    chk("R5", "up width after double ref", cnt_up[0], 8);
    chk("R5", "dn width after second fb", cnt_dn[0], 4);
    idle(2);

    tag = "R4";
    ref_d[0] = 1; tick(); tick();
    hiz[0] = 1; tick();
    chk("R4", "float up", if_up, 0);
    chk("R4", "float tri", if_tri, 1);
    hiz[0] = 0; tick();
    chk("R4", "state kept after float", if_up, 1);
    pwdn[0] = 1; tick();
    chk("R4", "pwdn tri", if_tri, 1);
    pwdn[0] = 0; tick();
    chk("R4", "state cleared by pwdn", if_up, 0);
    fb_d[0] = 1; tick();
    chk("R4", "fb after clear gives dn", if_dn, 1);
    idle(2);
    ref_d[0] = 1; tick(); tick();
    idle(2);

    tag = "R6";
    osel = 4'b0100;
    cmp(0, 6);
    chk("R6", "unlocked after wide", mon_out, 0);
    cmp(0, 1); cmp(0, 3); cmp(0, 0);
    chk("R6", "three good not locked", mon_out, 0);
    cmp(0, 1);
    chk("R6", "four good locked", mon_out, 1);
    tag = "R7";
    ref_d[0] = 1; tick();
    chk("R7", "lock pin low during pulse", mon_out, 0);
    fb_d[0] = 1; tick();
    chk("R7", "lock pin back high", mon_out, 1);
    idle(3);
    cmp(0, 4);
    chk("R6", "width at tolerance unlocks", mon_out, 0);
    for (int i = 0; i < 4; i++) cmp(0, 0);
    chk("R6", "zero width relocks", mon_out, 1);
    osel = 4'b1000; tick();
    chk("R7", "rf not locked", mon_out, 0);
    for (int i = 0; i < 4; i++) cmp(1, 2);
    chk("R7", "rf locked", mon_out, 1);
    osel = 4'b1100; tick();
    chk("R7", "both locked", mon_out, 1);
    cmp(1, -5);
    chk("R7", "both after rf loss", mon_out, 0);
    pwdn[0] = 1; osel = 4'b0100; tick(); pwdn[0] = 0; tick();
    chk("R4", "pwdn clears lock", mon_out, 0);

    tag = "R8";
    for (int s = 0; s < 8; s++) begin
      int codes [8] = '{1, 2, 5, 6, 9, 10, 13, 14};
      int sel;
      osel = 4'(codes[s]);
      sel = (codes[s] % 8 == 1) ? 0 : (codes[s] % 8 == 2) ? 1 : (codes[s] % 8 == 5) ? 2 : 3;
      for (int c = 0; c < 2; c++) begin ref_d[c] = 0; fb_d[c] = 0; end
      if (sel == 0) ref_d[0] = 1; else if (sel == 1) ref_d[1] = 1;
      else if (sel == 2) fb_d[0] = 1; else fb_d[1] = 1;
      tick();
      chk("R8", "selected divider high", mon_out, 1);
      for (int c = 0; c < 2; c++) begin ref_d[c] = !ref_d[c]; fb_d[c] = !fb_d[c]; end
      tick();
      chk("R8", "selected divider low", mon_out, 0);
      idle(2);
    end

    tag = "R9";
    for (int s = 0; s < 3; s++) begin
      int offc [3] = '{0, 7, 11};
      osel = 4'(offc[s]);
      for (int c = 0; c < 2; c++) begin ref_d[c] = 1; fb_d[c] = 1; end
      tick();
      chk("R9", "off code low", mon_out, 0);
      idle(2);
    end

    tag = "R11";
    osel = 4'b0011; creq[1] = 1; tick(); tick();
    chk("R11", "cur held without edge", rf_cur_hi, 0);
    chk("R10", "fastlock pin released", mon_out, 1);
    chk("R10", "flag low", fast_flag, 0);
    tag = "R10";
    cmp(1, 0);
    chk("R10", "high current flag", fast_flag, 1);
    chk("R10", "fastlock pin pulled low", mon_out, 0);
    chk("R11", "cur applied at edge", rf_cur_hi, 1);
    creq[1] = 0; fb_d[1] = 1; tick(); tick();
    chk("R11", "cur held after request drop", rf_cur_hi, 1);
    idle(2);
    cmp(1, 0);
    chk("R11", "cur dropped at next edge", rf_cur_hi, 0);
    creq[0] = 1; cmp(0, 1);
    chk("R11", "if cur applied", if_cur_hi, 1);
    osel = 4'b0100; tick();
    chk("R10", "flag low off fastlock", fast_flag, 0);

    tag = "R12";
    osel = 4'b0100;
    for (int i = 0; i < 4; i++) cmp(0, 1);
    chk("R12", "locked before clear", mon_out, 1);
    ref_d[0] = 1; tick();
    osel = 4'b1111; tick();
    chk("R12", "clear request", cnt_clr, 1);
    chk("R12", "pin low in clear", mon_out, 0);
    tick();
    chk("R12", "pump cleared", if_up, 0);
    osel = 4'b0100; tick();
    chk("R12", "lock cleared", mon_out, 0);
    idle(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule